// File: doc/BRIEF.md
# Daisy-Chain LED Refresh Controller

This controller sits on the host side of two cascaded 8-bit latched shift registers that switch 16 indicator LEDs. A client offers a 16-bit status word over a valid/ready handshake. The controller puts the word on a serial data line one bit at a time, starting with the most significant bit, and toggles a shift clock once for each bit. When all 16 bits are in place it raises a latch clock once, which moves the chain contents into the storage stage. A 1 in the word lights the matching LED and a 0 turns it off.

Setup, hold and pulse-width margins on the serial link are parameters counted in system-clock cycles. The integrator picks them so that they meet the register chain's minimums: at least 20 ns of data setup and hold around each rising shift edge, and at least 40 ns for every clock pulse. With the default 200 MHz clock the parameters are 4, 4 and 8 cycles.

The shared active-low output-enable line carries a free-running PWM signal for global dimming. The active-low chain-clear line is held asserted for a fixed number of cycles after reset, before the first word is accepted.

The sequencer has six states:
- `ST_CLEAR`: chain clear asserted. It moves to `ST_IDLE` once the clear time has elapsed.
- `ST_IDLE`: ready is high. It moves to `ST_LOW` when a word is accepted.
- `ST_LOW`: the shift clock is low and the current bit is on the data line. It moves to `ST_HIGH` when the low time ends.
- `ST_HIGH`: the shift clock is high. When the high time ends it goes back to `ST_LOW` for the next bit, or to `ST_GAP` after the last bit.
- `ST_GAP`: the shift clock stays low. It moves to `ST_LATCH` when the low time ends.
- `ST_LATCH`: the latch clock is high. It returns to `ST_IDLE` when the pulse time ends.

Top module: `led_chain_ctrl`

## Requirements
- R1: After reset is released, chain-clear stays low and ready stays low for exactly CLR_CYC cycles. Chain-clear then goes high and ready goes high. The clear empties both chained registers.
- R2: A word is taken on a clock edge where valid and ready are both high. Ready is low from the next cycle until the latch pulse has ended. While ready is low, valid and the word input are ignored.
- R3: Each accepted word produces exactly 16 rising shift-clock edges. Bit 15 is sent first, so it ends up in the far register (storage bits 15..8) and bit 0 ends up in the near register (storage bits 7..0).
- R4: Exactly one latch pulse follows the 16th shift pulse, and the latch clock is never high while the shift clock is high. After the pulse, the storage stage holds the accepted word, with 1 meaning LED on.
- R5: The data line is stable for at least SETUP_CYC cycles before each rising shift-clock edge.
- R6: The data line does not change while the shift clock is high, and the shift clock stays high for at least HOLD_CYC cycles.
- R7: The shift clock's high and low phases, and the latch clock's high phase, each last at least PULSE_CYC cycles.
- R8: With an 8-bit duty value D, the output-enable line is low for exactly D cycles in every window of 255 consecutive cycles.
- R9: Duty 0 keeps output-enable high at all times. Duty 255 keeps it low at all times, except while the chain is being cleared.
- R10: Output-enable is held high while chain-clear is asserted, whatever the duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| led_word_i | input | 16 | Status word, one bit per LED |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Controller can take a word |
| dim_duty_i | input | 8 | Global dimming duty, 0..255 |
| ser_data_o | output | 1 | Serial data to the chain |
| shift_clk_o | output | 1 | Shift clock, rising edge active |
| latch_clk_o | output | 1 | Storage latch clock, rising edge active |
| chain_clr_n_o | output | 1 | Chain clear, active low |
| out_en_n_o | output | 1 | Output enable with PWM, active low |

## Verification
The bench includes a model of the two-register chain and measures every edge on the link. It targets:
- A controller that shifts one bit too many or too few. The storage contents would then be off by one position.
- A controller that sends the bits least-significant first. The two bytes would come out swapped and reversed.
- A controller that changes data in the same cycle as the rising edge. The measured setup would then be zero.
- A controller that accepts a word offered in the middle of a sequence. This would corrupt the word in flight or trigger a second latch.

The PWM is checked at duty 0, 1, mid-scale and 255, where an off-by-one period or compare would show up as one cycle too many or too few. Reset is checked for the exact clear length and for output-enable being forced off during the clear.

// File: rtl/led_chain_pkg.sv
`timescale 1ns/1ps
package led_chain_pkg;
    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_LATCH
    } seq_state_t;
endpackage

// File: rtl/led_chain_seq.sv
`timescale 1ns/1ps
module led_chain_seq
    import led_chain_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SETUP_CYC = 4,
    parameter int HOLD_CYC  = 4,
    parameter int PULSE_CYC = 8,
    parameter int CLR_CYC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              ser_data_o,
    output logic              shift_clk_o,
    output logic              latch_clk_o,
    output logic              clr_n_o,
    output logic              clearing_o
);
    // Low phase serves both setup and low pulse width; high phase serves hold and high width.
    localparam int LOW_CYC  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int HIGH_CYC = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
    localparam int PH_MAX   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int TMR_MAX  = (PH_MAX > CLR_CYC) ? PH_MAX : CLR_CYC;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int IDX_W    = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
    localparam logic [TMR_W-1:0] LOW_END  = TMR_W'(LOW_CYC - 1);
    localparam logic [TMR_W-1:0] HIGH_END = TMR_W'(HIGH_CYC - 1);
    localparam logic [TMR_W-1:0] CLR_END  = TMR_W'(CLR_CYC - 1);

    seq_state_t        state_q, state_nx;
    logic [TMR_W-1:0]  tmr_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [WORD_W-1:0] shreg_q;

    // Next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_CLEAR: if (tmr_q == CLR_END)  state_nx = ST_IDLE;
            ST_IDLE:  if (valid_i)           state_nx = ST_LOW;
            ST_LOW:   if (tmr_q == LOW_END)  state_nx = ST_HIGH;
            ST_HIGH:  if (tmr_q == HIGH_END)
                          state_nx = (bit_idx_q == LAST_IDX) ? ST_GAP : ST_LOW;
            ST_GAP:   if (tmr_q == LOW_END)  state_nx = ST_LATCH;
            ST_LATCH: if (tmr_q == HIGH_END) state_nx = ST_IDLE;
            default:                         state_nx = ST_CLEAR;
        endcase
    end

    // State register with phase timer and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_CLEAR;
            tmr_q     <= '0;
            bit_idx_q <= '0;
            shreg_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (state_nx != state_q) tmr_q <= '0;
            else if (state_q != ST_IDLE) tmr_q <= tmr_q + 1'b1;

            if (state_q == ST_IDLE && valid_i) begin
                shreg_q   <= word_i;
                bit_idx_q <= '0;
            end else if (state_q == ST_HIGH && state_nx == ST_LOW) begin
                shreg_q   <= {shreg_q[WORD_W-2:0], 1'b0};
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        ready_o     = (state_q == ST_IDLE);
        clr_n_o     = (state_q != ST_CLEAR);
        clearing_o  = (state_q == ST_CLEAR);
        shift_clk_o = (state_q == ST_HIGH);
        latch_clk_o = (state_q == ST_LATCH);
        ser_data_o  = (state_q == ST_IDLE || state_q == ST_CLEAR) ? 1'b0 : shreg_q[WORD_W-1];
    end

    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!shift_clk_o && !latch_clk_o));
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && valid_i) |=> !ready_o);
    // R5
    setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk_o) |-> $stable(ser_data_o));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_clk_o && $past(shift_clk_o)) |-> $stable(ser_data_o));
    // R4
    latch_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clk_o |-> !shift_clk_o);
    // R3
    latch_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_clk_o) |-> (bit_idx_q == LAST_IDX));
endmodule

// File: rtl/led_chain_pwm.sv
`timescale 1ns/1ps
module led_chain_pwm #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              hold_off_i,
    output logic              oe_n_o
);
    // Period of 2^W - 1 cycles so that the full-scale code means always on.
    localparam logic [DUTY_W-1:0] CNT_LAST = DUTY_W'((2 ** DUTY_W) - 2);

    logic [DUTY_W-1:0] cnt_q;
    logic              oe_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            oe_n_q <= 1'b1;
        end else begin
            cnt_q  <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            oe_n_q <= hold_off_i || (cnt_q >= duty_i);
        end
    end

    assign oe_n_o = oe_n_q;

    // R10
    clear_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_off_i |=> oe_n_o);
    // R9
    duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(duty_i) == '0) |-> oe_n_o);
    // R9
    duty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(duty_i) == '1) && !$past(hold_off_i)) |-> !oe_n_o);
endmodule

// File: rtl/led_chain_ctrl.sv
`timescale 1ns/1ps
module led_chain_ctrl #(
    parameter int WORD_W    = 16,
    parameter int SETUP_CYC = 4,
    parameter int HOLD_CYC  = 4,
    parameter int PULSE_CYC = 8,
    parameter int CLR_CYC   = 8,
    parameter int DUTY_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] led_word_i,
    input  logic              word_valid_i,
    output logic              word_ready_o,
    input  logic [DUTY_W-1:0] dim_duty_i,
    output logic              ser_data_o,
    output logic              shift_clk_o,
    output logic              latch_clk_o,
    output logic              chain_clr_n_o,
    output logic              out_en_n_o
);
    logic clearing;

    led_chain_seq #(
        .WORD_W(WORD_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
        .PULSE_CYC(PULSE_CYC), .CLR_CYC(CLR_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .word_i(led_word_i), .valid_i(word_valid_i), .ready_o(word_ready_o),
        .ser_data_o(ser_data_o), .shift_clk_o(shift_clk_o),
        .latch_clk_o(latch_clk_o), .clr_n_o(chain_clr_n_o),
        .clearing_o(clearing)
    );

    led_chain_pwm #(.DUTY_W(DUTY_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .duty_i(dim_duty_i),
        .hold_off_i(clearing), .oe_n_o(out_en_n_o)
    );

    // R10
    clr_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_clr_n_o && $past(!chain_clr_n_o)) |-> out_en_n_o);
endmodule

// File: tb/led_chain_ctrl_test.sv
`timescale 1ns/1ps
module led_chain_ctrl_test;
    localparam int SU = 4, HO = 4, PW = 8, CL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word = '0;
    logic        valid = 1'b0;
    logic [7:0]  duty = 8'hFF;
    logic        ready, sdat, sck, lat, clr_n, oe_n;

    always #2.5 clk = ~clk;

    led_chain_ctrl #(.SETUP_CYC(SU), .HOLD_CYC(HO), .PULSE_CYC(PW), .CLR_CYC(CL)) uut (
        .clk(clk), .rst_n(rst_n), .led_word_i(word), .word_valid_i(valid),
        .word_ready_o(ready), .dim_duty_i(duty), .ser_data_o(sdat),
        .shift_clk_o(sck), .latch_clk_o(lat), .chain_clr_n_o(clr_n),
        .out_en_n_o(oe_n)
    );

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model of the two chained registers plus link timing monitor
    logic [7:0]  near_r = 8'hA5, far_r = 8'h5A;
    logic [15:0] store_r = '0;
    int rises = 0, lat_bits = 0, lat_words = 0;
    int viol_su = 0, viol_ho = 0, viol_pw = 0, viol_rdy = 0, viol_lat = 0;
    int stab = 1000, lo_cnt = 1000, hi_cnt = 0, lat_hi = 0;
    logic p_sck = 1'b0, p_lat = 1'b0, p_dat = 1'b0;

    always @(negedge clk) begin
        if (sdat != p_dat) stab = 1; else stab++;
        if (sck && !p_sck) begin
            if (stab - 1 < SU) viol_su++;
            if (lo_cnt < PW) viol_pw++;
            far_r  = {far_r[6:0], near_r[7]};
            near_r = {near_r[6:0], sdat};
            rises++;
            hi_cnt = 1;
        end else if (sck) begin
            hi_cnt++;
            if (sdat != p_dat) viol_ho++;
        end
        if (!sck && p_sck) begin
            if (hi_cnt < PW || hi_cnt < HO) viol_pw++;
            lo_cnt = 1;
        end else if (!sck) lo_cnt++;
        if (lat && !p_lat) begin
            if (sck) viol_lat++;
            lat_words++;
            lat_bits = rises;
            rises = 0;
            store_r = {far_r, near_r};
            lat_hi = 1;
        end else if (lat) lat_hi++;
        if (!lat && p_lat && lat_hi < PW) viol_pw++;
        if (ready && (sck || lat)) viol_rdy++;
        if (!clr_n) begin near_r = '0; far_r = '0; rises = 0; end
        p_sck = sck; p_lat = lat; p_dat = sdat;
    end

    task automatic wait_latch_done();
        int n = lat_words;
        while (lat_words == n) @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        while (!ready) @(negedge clk);
        word = w; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        check(ready == 1'b0, "R2", "ready after accept", ready, 0);
        wait_latch_done();
    endtask

    task automatic measure_pwm(input logic [7:0] d);
        int lows = 0;
        duty = d;
        repeat (300) @(negedge clk);
        for (int i = 0; i < 255; i++) begin
            if (!oe_n) lows++;
            @(negedge clk);
        end
        check(lows == int'(d), (d == 8'd0 || d == 8'hFF) ? "R9" : "R8",
              "oe low cycles per period", lows, d);
    endtask

    // {word, expected far byte, expected near byte}
    localparam logic [31:0] VEC [6] = '{
        32'h8000_8000, 32'h0001_0001, 32'hFFFF_FFFF,
        32'h0000_0000, 32'hA5C3_A5C3, 32'h1234_1234
    };

    initial begin
        #(5.0 * 150000);
        checks++; fails++;
        $display("FAIL watchdog run hung actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // Reset state (R1, R10)
        repeat (4) @(negedge clk);
        check(clr_n == 1'b0, "R1", "clear in reset", clr_n, 0);
        check(ready == 1'b0, "R1", "ready in reset", ready, 0);
        check(oe_n == 1'b1, "R10", "oe in reset", oe_n, 1);
        rst_n = 1'b1;
        repeat (CL - 1) @(posedge clk);
        @(negedge clk);
        check(clr_n == 1'b0, "R1", "clear at last clear cycle", clr_n, 0);
        check(oe_n == 1'b1, "R10", "oe during clear with full duty", oe_n, 1);
        check(ready == 1'b0, "R1", "ready during clear", ready, 0);
        @(posedge clk);
        @(negedge clk);
        check(clr_n == 1'b1, "R1", "clear released", clr_n, 1);
        check(ready == 1'b1, "R1", "ready after clear", ready, 1);
        check({far_r, near_r} == 16'h0, "R1", "chain emptied", {far_r, near_r}, 0);

        // Vector table walk (R3, R4, R5, R6, R7)
        for (int v = 0; v < 6; v++) begin
            send(VEC[v][31:16]);
            check(lat_bits == 16, "R3", "shift edges per word", lat_bits, 16);
            check(store_r[15:8] == VEC[v][15:8], "R3", "far byte msb first", store_r[15:8], VEC[v][15:8]);
            check(store_r == VEC[v][15:0], "R4", "latched word", store_r, VEC[v][15:0]);
            check(viol_su == 0, "R5", "setup violations", viol_su, 0);
            check(viol_ho == 0, "R6", "hold violations", viol_ho, 0);
            check(viol_pw == 0, "R7", "pulse width violations", viol_pw, 0);
            check(viol_lat == 0, "R4", "latch during shift", viol_lat, 0);
        end

        // Word offered while busy is ignored (R2)
        begin
            int n0;
            @(negedge clk);
            word = 16'h3C3C; valid = 1'b1;
            @(negedge clk);
            valid = 1'b0;
            n0 = lat_words;
            repeat (20) @(negedge clk);
            word = 16'hFFFF; valid = 1'b1;
            repeat (30) @(negedge clk);
            valid = 1'b0;
            wait_latch_done();
            check(store_r == 16'h3C3C, "R2", "busy word ignored", store_r, 16'h3C3C);
            check(lat_bits == 16, "R3", "bits with busy offer", lat_bits, 16);
            repeat (400) @(negedge clk);
            check(lat_words == n0 + 1, "R2", "no extra transfer", lat_words, n0 + 1);
            check(viol_rdy == 0, "R2", "ready during sequence", viol_rdy, 0);
        end

        // Dimming (R8, R9)
        measure_pwm(8'd0);
        measure_pwm(8'd1);
        measure_pwm(8'd128);
        measure_pwm(8'd255);

        // Dimming does not disturb shifting (R4)
        duty = 8'd77;
        send(16'h5AA5);
        check(store_r == 16'h5AA5, "R4", "word under dimming", store_r, 16'h5AA5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule